// File: doc/BRIEF.md
# B3ZS/HDB3 Bipolar Line Decoder

This block sits behind clock recovery on a bipolar line receiver. Each clock it takes one retimed line symbol as two rail bits: a positive pulse, a negative pulse, or neither. It removes zero-substitution codes and returns NRZ data.

One mode input picks the substitution rules. B3ZS is for DS3/STS-1 lines, where three zeros are sent as `00V` or `B0V`. HDB3 is for E3 lines, where four zeros are sent as `000V` or `B00V`. The block tracks the polarity of the last mark, so it can tell a bipolar violation that belongs to a legal substitution from one that does not. It raises a one-clock line-code-violation pulse for:

- an illegal violation;
- a symbol with both rails high;
- a zero run that reaches the mode's limit.

When the single-rail input is high, all decoding is bypassed. The positive rail then passes straight through and no violation is reported. The mode and single-rail inputs are expected to change only while reset is held.

Top module: `b3hd_decoder`

## Requirements
- R1: While reset is held, `data_o` and `lcv_o` are 0.
- R2: A mark is a symbol with exactly one rail high; `pos_i`=1 means a positive mark and `neg_i`=1 a negative one. A mark whose polarity differs from the previous mark decodes to 1, and an all-zero symbol decodes to 0. Each decoded bit appears on `data_o` after 3 rising edges in B3ZS mode (`mode_i`=0) and after 4 in HDB3 mode (`mode_i`=1).
- R3: In B3ZS mode, a mark with the same polarity as the previous mark, whose directly preceding symbol is zero, closes a legal substitution. That mark and the two symbols before it decode to 0, and no violation is flagged.
- R4: In HDB3 mode, a mark with the same polarity as the previous mark, whose two preceding symbols are zero, closes a legal substitution. That mark and the three symbols before it decode to 0, and no violation is flagged.
- R5: A same-polarity mark that does not meet the zero condition of the active mode drives `lcv_o` high for one cycle, one edge after it is sampled. It decodes to 1.
- R6: A symbol with both rails high drives `lcv_o` high for one cycle and decodes to 0. It leaves the stored last-mark polarity unchanged and ends any zero run.
- R7: In B3ZS mode, the third consecutive zero symbol drives `lcv_o` high for one cycle. Further zeros in the same run add no pulse.
- R8: In HDB3 mode, the fourth consecutive zero symbol drives `lcv_o` high for one cycle. A run of three zeros gives no pulse.
- R9: With `single_rail_i`=1, `data_o` equals `pos_i` from one edge earlier, `neg_i` has no effect, and `lcv_o` stays 0.
- R10: The first mark after reset is never treated as a violation, whatever its polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered line clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pos_i | input | 1 | Positive rail pulse for this symbol |
| neg_i | input | 1 | Negative rail pulse for this symbol |
| mode_i | input | 1 | 0 selects B3ZS, 1 selects HDB3 |
| single_rail_i | input | 1 | 1 bypasses decoding (NRZ on `pos_i`) |
| data_o | output | 1 | Decoded NRZ data |
| lcv_o | output | 1 | One-cycle line code violation pulse |

## Verification
The bench targets the following corner cases:

- **Substitution boundaries.** `B0V` against `00V`, and `B00V` against `000V`. A decoder that clears too few positions leaves a stray 1 in the data. One that clears too many erases a real mark that comes before the code.
- **Adjacent same-polarity marks.** These must be flagged, not decoded as a substitution. A design that skips the zero check hides real line errors.
- **Both rails high.** This must neither flip the stored polarity nor extend a zero run. A design that gets it wrong misjudges the next mark or mistimes the zero-run pulse.
- **Zero-run thresholds per mode.** A run of exactly three zeros in HDB3 must stay quiet, while a long run gives only one pulse. A wrong counter limit gives missing or repeated pulses.
- **First mark after reset.** This must not be flagged; a design with a stale polarity would flag it.

// File: rtl/b3hd_pkg.sv
package b3hd_pkg;

    // One received line symbol, classified from the two rails
    typedef enum logic [1:0] {
        SYM_ZERO = 2'd0,
        SYM_POS  = 2'd1,
        SYM_NEG  = 2'd2,
        SYM_BOTH = 2'd3
    } sym_e;

    function automatic sym_e classify(input logic p, input logic n);
        sym_e s;
        case ({n, p})
            2'b01:   s = SYM_POS;
            2'b10:   s = SYM_NEG;
            2'b11:   s = SYM_BOTH;
            default: s = SYM_ZERO;
        endcase
        return s;
    endfunction

    function automatic logic is_mark(input sym_e s);
        return (s == SYM_POS) || (s == SYM_NEG);
    endfunction

endpackage

// File: rtl/b3hd_polarity.sv
// Remembers the polarity of the last single-rail mark and reports when the
// current mark repeats it (a bipolar violation).
module b3hd_polarity
    import b3hd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  sym_e sym_i,
    output logic same_pol_o
);

    typedef struct packed {
        logic seen;
        logic last_neg;
    } pol_t;

    pol_t pol_d, pol_q;

    always_comb begin
        pol_d      = pol_q;
        same_pol_o = pol_q.seen &&
                     (((sym_i == SYM_POS) && !pol_q.last_neg) ||
                      ((sym_i == SYM_NEG) &&  pol_q.last_neg));
        if (is_mark(sym_i)) begin
            pol_d.seen     = 1'b1;
            pol_d.last_neg = (sym_i == SYM_NEG);
        end
        if (!en_i) begin
            pol_d      = '0;
            same_pol_o = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pol_q <= '0;
        else        pol_q <= pol_d;
    end

endmodule

// File: rtl/b3hd_zero_run.sv
// Counts consecutive zero symbols and fires once when a run reaches thr_i.
module b3hd_zero_run #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             zero_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             hit_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        hit_o = en_i && zero_i && (cnt_q == thr_i - CNT_W'(1));
        if (!en_i || !zero_i)  cnt_d = '0;
        else if (cnt_q >= thr_i) cnt_d = cnt_q;
        else                     cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/b3hd_decoder.sv
// B3ZS / HDB3 bipolar line decoder with violation and zero-run flagging.
module b3hd_decoder
    import b3hd_pkg::*;
#(
    parameter int B3_SPAN = 3,   // zero substitution length, B3ZS
    parameter int HD_SPAN = 4    // zero substitution length, HDB3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pos_i,
    input  logic neg_i,
    input  logic mode_i,
    input  logic single_rail_i,
    output logic data_o,
    output logic lcv_o
);

    localparam int DL_W   = HD_SPAN - 1;          // decoded bits held back
    localparam int HIST_W = HD_SPAN - 2;          // raw marks looked back at
    localparam int CNT_W  = $clog2(HD_SPAN + 1);

    typedef struct packed {
        logic [DL_W-1:0]   dl;     // decoded bits awaiting release
        logic [HIST_W-1:0] hist;   // raw nonzero flags of past symbols
        logic              out;
        logic              lcv;
    } dec_t;

    dec_t             st_d, st_q;
    sym_e             sym;
    logic             dec_en;
    logic             same_pol;
    logic             run_hit;
    logic [CNT_W-1:0] span;

    always_comb begin
        sym    = classify(pos_i, neg_i);
        dec_en = !single_rail_i;
        span   = mode_i ? CNT_W'(HD_SPAN) : CNT_W'(B3_SPAN);
    end

    b3hd_polarity u_pol (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (dec_en),
        .sym_i      (sym),
        .same_pol_o (same_pol)
    );

    b3hd_zero_run #(.CNT_W(CNT_W)) u_zrun (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (dec_en),
        .zero_i (sym == SYM_ZERO),
        .thr_i  (span),
        .hit_o  (run_hit)
    );

    int   tap;
    logic room_ok;
    logic legal;

    always_comb begin
        st_d    = st_q;
        tap     = int'(span) - 2;

        // a legal code needs zeros in the span-2 symbols just before V
        room_ok = 1'b1;
        for (int j = 0; j < HIST_W; j++) begin
            if (j < tap && st_q.hist[j]) room_ok = 1'b0;
        end
        legal = same_pol && room_ok;

        for (int j = HIST_W - 1; j > 0; j--) st_d.hist[j] = st_q.hist[j-1];
        st_d.hist[0] = (sym != SYM_ZERO);

        for (int j = DL_W - 1; j > 0; j--) st_d.dl[j] = st_q.dl[j-1];
        st_d.dl[0] = is_mark(sym) && !legal;

        st_d.out = st_q.dl[tap] && !legal;
        if (legal) begin
            for (int j = 0; j < DL_W; j++) begin
                if (j <= tap) st_d.dl[j] = 1'b0;
            end
        end

        st_d.lcv = (sym == SYM_BOTH) || (same_pol && !room_ok) || run_hit;

        if (!dec_en) begin
            st_d     = '0;
            st_d.out = pos_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o = st_q.out;
    assign lcv_o  = st_q.lcv;

endmodule

// File: rtl/b3hd_decoder_chk.sv
module b3hd_decoder_chk (
    input logic clk,
    input logic rst_n,
    input logic pos_i,
    input logic neg_i,
    input logic mode_i,
    input logic single_rail_i,
    input logic data_o,
    input logic lcv_o
);

    logic [2:0] zh_q;    // zero flags of the last three symbols
    logic [2:0] cyc_q;   // edges since reset, saturating

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zh_q  <= '0;
            cyc_q <= '0;
        end else begin
            zh_q  <= {zh_q[1:0], !pos_i && !neg_i};
            cyc_q <= (cyc_q == 3'd7) ? cyc_q : cyc_q + 3'd1;
        end
    end

    AST_BOTH_RAILS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!single_rail_i && pos_i && neg_i) |=> lcv_o);                        // R6

    AST_B3_THIRD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 3'd3 && !single_rail_i && !mode_i && !pos_i && !neg_i &&
         zh_q[0] && zh_q[1] && !zh_q[2]) |=> lcv_o);                          // R7

    AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 3'd1 && $past(single_rail_i)) |-> !lcv_o);                  // R9

    AST_BYPASS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 3'd1 && $past(single_rail_i)) |-> (data_o == $past(pos_i))); // R9

endmodule

bind b3hd_decoder b3hd_decoder_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pos_i         (pos_i),
    .neg_i         (neg_i),
    .mode_i        (mode_i),
    .single_rail_i (single_rail_i),
    .data_o        (data_o),
    .lcv_o         (lcv_o)
);

// File: tb/b3hd_decoder_bench.sv
`timescale 1ns/1ps
module b3hd_decoder_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pos_i = 1'b0, neg_i = 1'b0, mode_i = 1'b0, single_rail_i = 1'b0;
    logic data_o, lcv_o;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    b3hd_decoder u_b3hd_decoder (
        .clk(clk), .rst_n(rst_n), .pos_i(pos_i), .neg_i(neg_i),
        .mode_i(mode_i), .single_rail_i(single_rail_i),
        .data_o(data_o), .lcv_o(lcv_o)
    );

    // ---------------- behavioural reference model ----------------
    int last_pol;          // 0 none seen, +1 / -1
    int zrun;
    int dq[$];             // decoded bits, newest at the back
    int raw[$];            // 1 when the line symbol was nonzero
    int exp_data, exp_lcv;

    task automatic m_reset();
        last_pol = 0; zrun = 0;
        dq  = '{0, 0, 0, 0};
        raw = '{0, 0, 0, 0};
        exp_data = 0; exp_lcv = 0;
    endtask

    task automatic m_step(input int p, input int n);
        int d, pol, bitv, lcv;
        bit v, legal;
        if (single_rail_i) begin
            exp_data = p; exp_lcv = 0;
            return;
        end
        d = mode_i ? 4 : 3;
        lcv = 0; bitv = 0;
        if (p && n) begin
            lcv = 1; zrun = 0;
        end else if (!p && !n) begin
            zrun++;
            if (zrun == d) lcv = 1;
        end else begin
            zrun = 0;
            pol = p ? 1 : -1;
            v = (last_pol != 0) && (pol == last_pol);
            legal = v;
            for (int j = 0; j < d - 2; j++)
                if (raw[raw.size() - 1 - j] != 0) legal = 0;
            if (legal) begin
                for (int j = 1; j < d; j++) dq[dq.size() - j] = 0;
            end else begin
                bitv = 1;
                if (v) lcv = 1;
            end
            last_pol = pol;
        end
        raw.push_back((p || n) ? 1 : 0);
        dq.push_back(bitv);
        exp_data = dq[dq.size() - d];
        exp_lcv  = lcv;
        while (dq.size() > 8)  void'(dq.pop_front());
        while (raw.size() > 8) void'(raw.pop_front());
    endtask

    always @(posedge clk) begin
        if (!rst_n) m_reset();
        else        m_step(int'(pos_i), int'(neg_i));
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t",
                     cur_req, what, act, exp, $time);
        end
    endtask

    // compare results of the previous symbol, then drive the next one
    task automatic send(input logic p, input logic n);
        @(negedge clk);
        chk("data_o", int'(data_o), exp_data);
        chk("lcv_o",  int'(lcv_o),  exp_lcv);
        pos_i = p; neg_i = n;
    endtask

    task automatic zeros(input int k);
        for (int i = 0; i < k; i++) send(1'b0, 1'b0);
    endtask

    task automatic do_reset(input logic m, input logic s);
        @(negedge clk);
        rst_n = 1'b0; pos_i = 1'b0; neg_i = 1'b0;
        mode_i = m; single_rail_i = s;
        cur_req = "R1";
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("reset data_o", int'(data_o), 0);
            chk("reset lcv_o",  int'(lcv_o),  0);
        end
        pos_i = 1'b1; neg_i = 1'b1;   // rails busy while reset still held
        @(negedge clk);
        chk("reset data_o", int'(data_o), 0);
        chk("reset lcv_o",  int'(lcv_o),  0);
        pos_i = 1'b0; neg_i = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // ---- B3ZS ----
        do_reset(1'b0, 1'b0);
        cur_req = "R10"; send(1, 0); send(0, 1);               // first mark, no flag
        cur_req = "R2";
        send(1, 0); send(0, 0); send(0, 1); send(1, 0); send(0, 0); send(0, 1); zeros(2);
        cur_req = "R3";
        send(1, 0); send(0, 0); send(0, 0); send(1, 0);        // 00V
        send(0, 1); send(0, 0); send(0, 1);                    // B0V
        send(1, 0); send(0, 0); send(1, 0);                    // B0V right after
        send(0, 1); zeros(2);
        cur_req = "R5";
        send(1, 0); send(1, 0); send(0, 1); send(0, 1); send(0, 0);
        cur_req = "R6";
        send(1, 0); send(1, 1); send(0, 1); send(0, 0); send(1, 1); send(0, 0); send(0, 0);
        cur_req = "R7";
        send(1, 0); zeros(7); send(0, 1); zeros(2); send(1, 0); zeros(3);

        // ---- HDB3 ----
        do_reset(1'b1, 1'b0);
        cur_req = "R10"; send(0, 1); send(1, 0);
        cur_req = "R2";
        send(0, 1); send(1, 0); send(0, 0); send(0, 1); zeros(2);
        cur_req = "R4";
        send(1, 0); zeros(3); send(1, 0);                      // 000V
        send(0, 1); zeros(2); send(0, 1);                      // B00V
        send(1, 0); send(0, 0); send(0, 0); send(1, 0);        // B00V again
        send(0, 1); zeros(1);
        cur_req = "R5";
        send(1, 0); send(0, 0); send(1, 0);                    // one zero only
        send(0, 1); send(0, 1); zeros(2);
        cur_req = "R8";
        send(1, 0); zeros(3); send(0, 1); zeros(6); send(1, 0); zeros(4);
        cur_req = "R6";
        send(1, 1); send(0, 1); zeros(1);

        // ---- mixed random traffic, both modes ----
        for (int m = 0; m < 2; m++) begin
            do_reset(m[0], 1'b0);
            cur_req = "R5";
            for (int i = 0; i < 400; i++) begin
                int r = $urandom_range(0, 9);
                if (r < 4)       send(0, 0);
                else if (r < 9)  send(r[0], !r[0]);
                else             send(1, 1);
            end
            zeros(5);
        end

        // ---- single-rail bypass ----
        do_reset(1'b0, 1'b1);
        cur_req = "R9";
        for (int i = 0; i < 200; i++) send($urandom_range(0, 1), $urandom_range(0, 1));
        do_reset(1'b1, 1'b1);
        for (int i = 0; i < 50; i++) send(1'b1, 1'b1);
        send(0, 1); send(0, 1);
        zeros(2);

        finish_run();
    end

endmodule